// File: doc/BRIEF.md
# Timer Capture/Compare Channel Register

This block is one general register of a timer channel together with the logic for its pin. A 4-bit mode field gives the register one of two roles. As a compare register it holds a value. Whenever the free-running counter advances and equals that value, the pin is driven low, driven high or toggled, and a sticky event flag is raised. As a capture register it copies the counter into itself when a chosen event occurs. The event is a rising, falling or either edge of the synchronized pin input, or a count step of the neighbouring channel's counter.

Two flags from the rest of the timer can veto the function. A buffer-mode flag reduces the register to a plain holding register, with no matching and no capturing. A flag reporting that the neighbouring counter runs from the undivided clock makes the neighbour-driven capture source invalid. All ports are plain control and status signals. Writes take effect at the clock edge, and there is no handshake or back-pressure.

Top module: `tgc_channel`

## Requirements
- R1: After reset the mode field is 0000, `gr_value` is 0, `pin_out` is 0, `pin_oe` is 0 and `evt_flag` is 0.
- R2: Writing a mode value whose bit 3 is 0 loads bit 2 of that value into `pin_out`, visible in the cycle after the write. This load has priority over a compare action in the same cycle.
- R3: In compare mode (bit 3 = 0), bits 1:0 give the match action: 00 no output (`pin_oe` low, pin level held), 01 drive 0, 10 drive 1, 11 toggle. `pin_oe` is high when bits 1:0 are not 00 and buffer mode is off. Without a match or a compare-mode write, `pin_out` holds.
- R4: A match occurs when `cnt_tick` is high and `cnt_val` equals `gr_value`, in compare mode with buffer mode off. Each match or capture sets `evt_flag` from the next cycle on. `evt_flag_clr` clears it, and a set in the same cycle wins over the clear.
- R5: Mode 1000 captures on a rising pin edge. The pin passes two synchronizer flops, and `cnt_val` is latched at the third rising clock edge counted from the first edge that samples the new pin level.
- R6: Mode 1001 captures on a falling pin edge, with the same latency as R5.
- R7: Modes 1010 and 1011 capture on either pin edge, with the same latency as R5.
- R8: Modes 11xx capture `cnt_val` at every clock edge where `nbr_cnt_evt` is high.
- R9: While `nbr_fast_clk` is high, modes 11xx never capture.
- R10: While `buf_mode` is high there is no match, no capture and no flag set, `pin_oe` is low and `pin_out` changes only through R2 writes. `gr_wr` still loads `gr_value`.
- R11: A capture and a `gr_wr` in the same cycle leave the captured counter value in `gr_value`.
- R12: In capture mode (bit 3 = 1) `pin_oe` is low and `pin_out` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current value of the free-running counter |
| cnt_tick | input | 1 | Counter advances at this edge |
| pin_in | input | 1 | Asynchronous pin input |
| nbr_cnt_evt | input | 1 | Neighbouring counter steps up or down this cycle |
| nbr_fast_clk | input | 1 | Neighbouring counter runs from the undivided clock |
| buf_mode | input | 1 | Register acts as a buffer only |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 4 | New mode field value |
| gr_wr | input | 1 | Write strobe for the general register |
| gr_wdata | input | CNT_W | New general register value |
| evt_flag_clr | input | 1 | Clear the event flag |
| gr_value | output | CNT_W | General register contents |
| pin_out | output | 1 | Pin level |
| pin_oe | output | 1 | Pin output enable |
| evt_flag | output | 1 | Sticky match/capture flag |

## Verification
Two pairs of functions can fall in the same cycle, and both are provoked on purpose. First, an event can set the flag in the same cycle that software clears it. The bench holds `evt_flag_clr` high across a window around a known match and around a neighbour-driven capture, and the flag must stay set. Second, a capture can coincide with a bus write of the register. The bench pulses `gr_wr` in the same cycle as `nbr_cnt_evt`, and the register must hold the counter value. A cycle-level reference model in the bench predicts all four outputs. Each outcome is judged by comparing the outputs against that model on every clock.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } cmp_act_e;

  typedef enum logic [1:0] {
    SRC_RISE = 2'b00,
    SRC_FALL = 2'b01,
    SRC_BOTH = 2'b10,
    SRC_NBR  = 2'b11
  } cap_src_e;

  typedef struct packed {
    logic     is_capture;
    logic     init_lvl;
    cmp_act_e act;
    cap_src_e src;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [3:0] f);
    mode_dec_t d;
    d.is_capture = f[3];
    d.init_lvl   = f[2];
    d.act        = cmp_act_e'(f[1:0]);
    if (f[2])      d.src = SRC_NBR;
    else if (f[1]) d.src = SRC_BOTH;
    else if (f[0]) d.src = SRC_FALL;
    else           d.src = SRC_RISE;
    return d;
  endfunction

endpackage

// File: rtl/tgc_decode.sv
module tgc_decode
  import tgc_pkg::*;
(
  input  logic [3:0] mode_q,
  input  logic       buf_mode,
  input  logic       nbr_fast_clk,
  output mode_dec_t  dec,
  output logic       cmp_en,
  output logic       cap_en,
  output logic       oe_en
);

  always_comb begin
    dec    = decode_mode(mode_q);
    cmp_en = !buf_mode && !dec.is_capture;
    oe_en  = cmp_en && (dec.act != ACT_OFF);
    cap_en = !buf_mode && dec.is_capture &&
             !((dec.src == SRC_NBR) && nbr_fast_clk);
  end

endmodule

// File: rtl/tgc_capture.sv
module tgc_capture
  import tgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_in,
  input  logic     nbr_cnt_evt,
  input  logic     cap_en,
  input  cap_src_e src,
  output logic     cap_evt
);

  localparam int HIST_W = SYNC_STAGES + 1;

  logic [HIST_W-1:0] hist_q;
  logic              cur_lvl, prev_lvl, rise, fall, raw_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[HIST_W-2:0], pin_in};
  end

  assign cur_lvl  = hist_q[SYNC_STAGES-1];
  assign prev_lvl = hist_q[SYNC_STAGES];
  assign rise     = cur_lvl && !prev_lvl;
  assign fall     = !cur_lvl && prev_lvl;

  always_comb begin
    unique case (src)
      SRC_RISE: raw_evt = rise;
      SRC_FALL: raw_evt = fall;
      SRC_BOTH: raw_evt = rise || fall;
      default:  raw_evt = nbr_cnt_evt;
    endcase
  end

  assign cap_evt = cap_en && raw_evt;

  AST_NO_EVT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !cap_evt); // R10

endmodule

// File: rtl/tgc_pin_ctrl.sv
module tgc_pin_ctrl
  import tgc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld_init,
  input  logic     init_lvl,
  input  logic     match,
  input  cmp_act_e act,
  input  logic     oe_en,
  output logic     pin_out,
  output logic     pin_oe
);

  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (ld_init) begin
      pin_q <= init_lvl;
    end else if (match) begin
      unique case (act)
        ACT_LOW:    pin_q <= 1'b0;
        ACT_HIGH:   pin_q <= 1'b1;
        ACT_TOGGLE: pin_q <= !pin_q;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign pin_out = pin_q;
  assign pin_oe  = oe_en;

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_init && !match) |=> $stable(pin_q)); // R3

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_init |=> (pin_q == $past(init_lvl))); // R2

endmodule

// File: rtl/tgc_channel.sv
module tgc_channel
  import tgc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_tick,
  input  logic             pin_in,
  input  logic             nbr_cnt_evt,
  input  logic             nbr_fast_clk,
  input  logic             buf_mode,
  input  logic             mode_wr,
  input  logic [3:0]       mode_wdata,
  input  logic             gr_wr,
  input  logic [CNT_W-1:0] gr_wdata,
  input  logic             evt_flag_clr,
  output logic [CNT_W-1:0] gr_value,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             evt_flag
);

  logic [3:0]       mode_q;
  logic [CNT_W-1:0] gr_q;
  logic             flag_q;
  mode_dec_t        dec;
  logic             cmp_en, cap_en, oe_en, cap_evt, match, ld_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 4'b0000;
    else if (mode_wr) mode_q <= mode_wdata;
  end

  tgc_decode u_decode (
    .mode_q       (mode_q),
    .buf_mode     (buf_mode),
    .nbr_fast_clk (nbr_fast_clk),
    .dec          (dec),
    .cmp_en       (cmp_en),
    .cap_en       (cap_en),
    .oe_en        (oe_en)
  );

  tgc_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_in      (pin_in),
    .nbr_cnt_evt (nbr_cnt_evt),
    .cap_en      (cap_en),
    .src         (dec.src),
    .cap_evt     (cap_evt)
  );

  assign match   = cmp_en && cnt_tick && (cnt_val == gr_q);
  assign ld_init = mode_wr && !mode_wdata[3];

  tgc_pin_ctrl u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_init  (ld_init),
    .init_lvl (mode_wdata[2]),
    .match    (match),
    .act      (dec.act),
    .oe_en    (oe_en),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gr_q <= '0;
    else if (cap_evt) gr_q <= cnt_val;
    else if (gr_wr)   gr_q <= gr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (match || cap_evt) flag_q <= 1'b1;
    else if (evt_flag_clr)     flag_q <= 1'b0;
  end

  assign gr_value = gr_q;
  assign evt_flag = flag_q;

  AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (gr_q == $past(cnt_val))); // R11

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (match || cap_evt) |=> flag_q); // R4

  AST_FAST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q[3:2] == 2'b11) && nbr_fast_clk) |-> !cap_evt); // R9

  AST_BUF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && !flag_q) |=> !flag_q); // R10

  AST_OE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (!mode_q[3] && !buf_mode)); // R12

endmodule

// File: tb/tgc_channel_tb.sv
module tgc_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [W-1:0] cnt_val = 0;
  logic         cnt_tick = 1;
  logic         pin_in = 0, nbr_cnt_evt = 0, nbr_fast_clk = 0, buf_mode = 0;
  logic         mode_wr = 0, gr_wr = 0, evt_flag_clr = 0;
  logic [3:0]   mode_wdata = 0;
  logic [W-1:0] gr_wdata = 0;
  logic [W-1:0] gr_value;
  logic         pin_out, pin_oe, evt_flag;

  int    n_cmp = 0, n_bad = 0;
  string phase = "R1";
  bit    started = 0;

  // reference model state
  logic [3:0]   m_mode = 0;
  logic [W-1:0] m_gr = 0;
  bit           m_pin = 0, m_flag = 0;
  bit           ph[$] = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  tgc_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
    .pin_in(pin_in), .nbr_cnt_evt(nbr_cnt_evt), .nbr_fast_clk(nbr_fast_clk),
    .buf_mode(buf_mode), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .gr_wr(gr_wr), .gr_wdata(gr_wdata), .evt_flag_clr(evt_flag_clr),
    .gr_value(gr_value), .pin_out(pin_out), .pin_oe(pin_oe), .evt_flag(evt_flag)
  );

  always @(posedge clk) begin
    bit match, cap, rise, fall, nxt_pin, nxt_flag;
    logic [W-1:0] nxt_gr;
    started = 1;
    if (!rst_n) begin
      m_mode = 0; m_gr = 0; m_pin = 0; m_flag = 0; ph = '{0, 0, 0};
    end else begin
      rise  = ph[1] && !ph[0];
      fall  = !ph[1] && ph[0];
      match = !buf_mode && !m_mode[3] && cnt_tick && (cnt_val == m_gr);
      cap   = 0;
      if (!buf_mode && m_mode[3]) begin
        if (m_mode[2])      cap = nbr_cnt_evt && !nbr_fast_clk;
        else if (m_mode[1]) cap = rise || fall;
        else if (m_mode[0]) cap = fall;
        else                cap = rise;
      end
      nxt_pin = m_pin;
      if (mode_wr && !mode_wdata[3]) nxt_pin = mode_wdata[2];
      else if (match) begin
        if (m_mode[1:0] == 2'b01) nxt_pin = 0;
        else if (m_mode[1:0] == 2'b10) nxt_pin = 1;
        else if (m_mode[1:0] == 2'b11) nxt_pin = !m_pin;
      end
      nxt_flag = (match || cap) ? 1 : (evt_flag_clr ? 0 : m_flag);
      nxt_gr   = cap ? cnt_val : (gr_wr ? gr_wdata : m_gr);
      if (mode_wr) m_mode = mode_wdata;
      m_pin = nxt_pin; m_flag = nxt_flag; m_gr = nxt_gr;
      ph.push_back(pin_in);
      void'(ph.pop_front());
    end
  end

  task automatic chk1(string nm, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", phase, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk1("gr_value", gr_value, m_gr);
      chk1("pin_out", W'(pin_out), W'(m_pin));
      chk1("pin_oe", W'(pin_oe),
           W'(!buf_mode && !m_mode[3] && (m_mode[1:0] != 2'b00)));
      chk1("evt_flag", W'(evt_flag), W'(m_flag));
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(negedge clk); #1;
      if (cnt_tick) cnt_val = cnt_val + 1'b1;
      mode_wr = 0; gr_wr = 0; nbr_cnt_evt = 0;
    end
  endtask

  task automatic set_mode(logic [3:0] m);
    mode_wdata = m; mode_wr = 1; cyc();
  endtask

  task automatic set_gr(logic [W-1:0] v);
    gr_wdata = v; gr_wr = 1; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    phase = "R1"; cyc(3); rst_n = 1; cyc(2);

    // compare mode: initial levels and match actions
    phase = "R2"; set_mode(4'b0100); cyc(2); set_mode(4'b0000); cyc(2);
    phase = "R3"; set_gr(cnt_val + 4); set_mode(4'b0011); cyc(8);
    set_gr(cnt_val + 3); cyc(6);
    set_mode(4'b0101); set_gr(cnt_val + 3); cyc(6);
    set_mode(4'b0010); set_gr(cnt_val + 3); cyc(6);
    set_mode(4'b0000); set_gr(cnt_val + 2); cyc(5);

    // match only on tick; set beats clear
    phase = "R4"; set_mode(4'b0011); evt_flag_clr = 1; cyc(2); evt_flag_clr = 0;
    cnt_tick = 0; set_gr(cnt_val); cyc(4); cnt_tick = 1; cyc(2);
    evt_flag_clr = 1; cyc(); evt_flag_clr = 0;
    set_gr(cnt_val + 3); evt_flag_clr = 1; cyc(6); evt_flag_clr = 0; cyc(2);
    phase = "R2"; set_gr(cnt_val + 2); cyc(); mode_wdata = 4'b0111; mode_wr = 1; cyc(3);

    // pin-edge captures
    phase = "R5"; set_mode(4'b1000); evt_flag_clr = 1; cyc(); evt_flag_clr = 0;
    pin_in = 1; cyc(6); pin_in = 0; cyc(6); pin_in = 1; cyc(1); pin_in = 0; cyc(6);
    phase = "R6"; set_mode(4'b1001); pin_in = 1; cyc(5); pin_in = 0; cyc(6);
    phase = "R7"; set_mode(4'b1010); pin_in = 1; cyc(5); pin_in = 0; cyc(5);
    set_mode(4'b1011); pin_in = 1; cyc(5); pin_in = 0; cyc(5);
    phase = "R12"; set_mode(4'b1011); cyc(3);

    // neighbour-driven capture
    phase = "R8"; set_mode(4'b1100); evt_flag_clr = 1; cyc(); evt_flag_clr = 0;
    nbr_cnt_evt = 1; cyc(); cyc(2); cnt_tick = 0; nbr_cnt_evt = 1; cyc();
    cnt_tick = 1; set_mode(4'b1111); evt_flag_clr = 1; nbr_cnt_evt = 1; cyc(); evt_flag_clr = 0; cyc(2);
    phase = "R9"; nbr_fast_clk = 1; evt_flag_clr = 1; cyc(); evt_flag_clr = 0;
    repeat (4) begin nbr_cnt_evt = 1; cyc(); end
    phase = "R5"; set_mode(4'b1000); pin_in = 1; cyc(5); pin_in = 0; cyc(2);
    nbr_fast_clk = 0;
    phase = "R11"; set_mode(4'b1100); gr_wdata = 16'h5A5A; gr_wr = 1; nbr_cnt_evt = 1; cyc(2);
    set_gr(16'h1234); cyc(2);

    // buffer mode vetoes everything
    phase = "R10"; buf_mode = 1; evt_flag_clr = 1; cyc(); evt_flag_clr = 0;
    repeat (3) begin nbr_cnt_evt = 1; cyc(); end
    set_mode(4'b1010); pin_in = 1; cyc(5); pin_in = 0; cyc(5);
    set_mode(4'b0111); set_gr(cnt_val + 2); cyc(5);
    set_gr(16'hBEEF); cyc(2);
    buf_mode = 0; set_gr(cnt_val + 2); cyc(5);

    phase = "R1"; rst_n = 0; cyc(2); rst_n = 1; cyc(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule